// File: doc/BRIEF.md
# HDLC Receive Deframer

This block turns a bit-serial HDLC line into a stream of frame bytes. Each received line bit arrives on `rx_bit` together with a one-cycle `bit_en` strobe, so the block can sit behind any channel selector that already picks the bits of one time slot. It finds the 0x7E flags that bound frames and removes the zero inserted after every five ones. It checks the 16-bit frame check sequence and spots runs of ones that mean abort or an idle line.

Data bytes leave on `out_valid`/`out_data`, and the first byte of each frame carries `out_first`. Each delivered frame then ends with a one-cycle `eof_valid` pulse. That pulse carries three status bits: CRC error, abort, and a length that is not a whole number of bytes. The two check-sequence bytes are never delivered. A frame that is too short never shows up at the outputs, so downstream storage only sees frames worth keeping. `line_active` and `idle` report the state of the line.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: The pattern 0,1,1,1,1,1,1,0 on consecutive strobed bits is a flag; bits between two flags form a frame, one flag may close one frame and open the next, bytes are assembled least significant bit first (the first bit received lands in `out_data[0]`), and the first delivered byte of a frame has `out_first`=1.
- R2: Inside a frame, a 0 that follows five consecutive 1s is removed and contributes nothing to data or CRC.
- R3: The check runs over all frame bits with a register preset to 0xFFFF, shifted least significant bit first with the reflected form 0x8408 of x^16+x^12+x^5+1; at the closing flag `eof_crc_err` is 0 exactly when the register holds 0xF0B8.
- R4: Seven consecutive 1s abort an open frame and drop `line_active`; if the frame had already reached the minimum length, an end pulse follows with `eof_abort`=1, `eof_crc_err`=0, `eof_nonint`=0, and its last two completed bytes are not delivered; otherwise nothing is output.
- R5: `idle` becomes 1 on the strobe that completes fifteen consecutive 1s and returns to 0 on the next strobed 0.
- R6: A frame whose whole-byte count, check bytes included, is below n = 3 + `min_len_sel` (00=3, 01=4, 10=5, 11=6) produces no byte and no end pulse.
- R7: While `rx_en` is 0 nothing is delivered, all frame state is cleared and `line_active` is 0; after it returns to 1 a new flag is needed before a frame is accepted.
- R8: `line_active` becomes 1 after a flag is received with `rx_en` high and stays 1 across frames and interframe flags until an abort.
- R9: The two check-sequence bytes are never delivered; the end pulse follows the last data byte and never shares a cycle with a byte.
- R10: `eof_nonint` is 1 when the closing flag arrives after a number of frame bits that is not a multiple of eight.
- R11: After reset `out_valid`, `eof_valid`, `line_active` and `idle` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; low clears and silences the block |
| min_len_sel | input | 2 | Minimum frame length select, n = 3 + value |
| bit_en | input | 1 | One-cycle strobe marking a valid line bit |
| rx_bit | input | 1 | Serial line bit, sampled when `bit_en` is 1 |
| out_valid | output | 1 | Data byte valid |
| out_first | output | 1 | Byte is the first of its frame |
| out_data | output | 8 | Received data byte |
| eof_valid | output | 1 | End-of-frame pulse |
| eof_crc_err | output | 1 | Frame check sequence wrong |
| eof_abort | output | 1 | Frame ended by abort |
| eof_nonint | output | 1 | Frame length not a whole number of bytes |
| line_active | output | 1 | Flags or frames are being received |
| idle | output | 1 | Fifteen or more consecutive ones seen |

## Verification
The properties assume that `bit_en` strobes are at least one idle cycle apart when a frame closes, so the few pending bytes can drain before the next frame produces a byte. They also assume `min_len_sel` is held steady during a frame. The stimulus strobes one bit every third cycle and changes the length select only between frames, after a closing flag. Stuffing, flags and abort runs are built by the bench's own bit generator, so every frame it sends is well formed except where a test corrupts it on purpose.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_R  = 16'h8408;
  localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;

  typedef enum logic [1:0] {
    BK_NONE  = 2'd0,
    BK_DATA  = 2'd1,
    BK_FLAG  = 2'd2,
    BK_ABORT = 2'd3
  } bit_kind_e;

  typedef struct packed {
    logic crc_err;
    logic aborted;
    logic nonint;
  } frm_stat_t;

  function automatic logic [15:0] crc_next(input logic [15:0] cur, input logic din);
    logic fb;
    fb = cur[0] ^ din;
    crc_next = (cur >> 1) ^ (fb ? CRC_POLY_R : 16'h0000);
  endfunction
endpackage

// File: rtl/hdlc_rx_bitclass.sv
module hdlc_rx_bitclass
  import hdlc_rx_pkg::*;
#(
  parameter int STUFF_ONES = 5,
  parameter int ABORT_ONES = 7,
  parameter int IDLE_ONES  = 15
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      enable,
  input  logic      bit_en,
  input  logic      rx_bit,
  output bit_kind_e kind,
  output logic      idle_o
);
  localparam int CW = $clog2(IDLE_ONES + 1);
  localparam logic [CW-1:0] STUFF_C = CW'(STUFF_ONES);
  localparam logic [CW-1:0] FLAG_C  = CW'(STUFF_ONES + 1);
  localparam logic [CW-1:0] ABRT_C  = CW'(ABORT_ONES - 1);
  localparam logic [CW-1:0] IDLE_C  = CW'(IDLE_ONES);
  localparam logic [CW-1:0] IDLM_C  = CW'(IDLE_ONES - 1);

  logic [CW-1:0] ones_q;
  logic          idle_q;

  always_comb begin
    kind = BK_NONE;
    if (bit_en && enable) begin
      if (ones_q < STUFF_C) begin
        kind = BK_DATA;
      end else if (rx_bit && ones_q == ABRT_C) begin
        kind = BK_ABORT;
      end else if (!rx_bit && ones_q == FLAG_C) begin
        kind = BK_FLAG;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      ones_q <= '0;
      idle_q <= 1'b0;
    end else if (bit_en) begin
      if (rx_bit) begin
        if (ones_q != IDLE_C) ones_q <= ones_q + 1'b1;
        if (ones_q >= IDLM_C) idle_q <= 1'b1;
      end else begin
        ones_q <= '0;
        idle_q <= 1'b0;
      end
    end
  end

  assign idle_o = idle_q;
endmodule

// File: rtl/hdlc_rx_crc16.sv
module hdlc_rx_crc16
  import hdlc_rx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic shift,
  input  logic din,
  output logic good_o
);
  logic [15:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || clear) crc_q <= CRC_PRESET;
    else if (shift)   crc_q <= crc_next(crc_q, din);
  end

  assign good_o = (crc_q == CRC_RESIDUE);
endmodule

// File: rtl/hdlc_rx_byte_fifo.sv
module hdlc_rx_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH):0]     level
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_q, rd_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_q[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else if (pop) dout <= mem[rd_q[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push) wr_q <= wr_q + 1'b1;
      if (pop)  rd_q <= rd_q + 1'b1;
    end
  end

  assign level = wr_q - rd_q;
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int MIN_BASE   = 3,
  parameter int FIFO_DEPTH = 8,
  parameter int STUFF_ONES = 5,
  parameter int ABORT_ONES = 7,
  parameter int IDLE_ONES  = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_en,
  input  logic [1:0] min_len_sel,
  input  logic       bit_en,
  input  logic       rx_bit,
  output logic       out_valid,
  output logic       out_first,
  output logic [7:0] out_data,
  output logic       eof_valid,
  output logic       eof_crc_err,
  output logic       eof_abort,
  output logic       eof_nonint,
  output logic       line_active,
  output logic       idle
);
  localparam int DLY   = STUFF_ONES + 1;
  localparam int DCW   = $clog2(DLY + 1);
  localparam int MAXN  = MIN_BASE + 3;
  localparam int CNT_W = $clog2(MAXN + 1) + 1;
  localparam int LVW   = $clog2(FIFO_DEPTH) + 1;
  localparam logic [DCW-1:0]   DLY_C   = DCW'(DLY);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [LVW-1:0]   HOLD_C  = LVW'(2);

  logic            clr;
  bit_kind_e       kind;
  logic            crc_good;
  logic [LVW-1:0]  level;
  logic [7:0]      fifo_dout;

  logic            open_q;
  logic [DLY-1:0]  dly_q;
  logic [DCW-1:0]  dly_cnt_q;
  logic [7:0]      asm_q;
  logic [2:0]      phase_q;
  logic [CNT_W-1:0] byte_cnt_q;
  logic            started_q, first_pend_q, close_pend_q;
  frm_stat_t       stat_q;

  logic            data_push, exit_vld, byte_done, flag_hit, abort_hit;
  logic            frame_ok, start_now, pop, close_eof, abort_eof, eof_fire, flush;
  logic [7:0]      asm_next;
  logic [CNT_W-1:0] min_n;
  frm_stat_t       eof_stat;

  assign clr = rst || !rx_en;

  hdlc_rx_bitclass #(
    .STUFF_ONES(STUFF_ONES), .ABORT_ONES(ABORT_ONES), .IDLE_ONES(IDLE_ONES)
  ) u_cls (
    .clk(clk), .rst(rst), .enable(rx_en), .bit_en(bit_en), .rx_bit(rx_bit),
    .kind(kind), .idle_o(idle)
  );

  hdlc_rx_crc16 u_crc (
    .clk(clk), .rst(rst), .clear(flag_hit || abort_hit), .shift(exit_vld),
    .din(dly_q[0]), .good_o(crc_good)
  );

  hdlc_rx_byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(clr), .flush(flush), .push(byte_done), .din(asm_next),
    .pop(pop), .dout(fifo_dout), .level(level)
  );

  always_comb begin
    min_n     = CNT_W'(MIN_BASE) + CNT_W'(min_len_sel);
    data_push = open_q && (kind == BK_DATA);
    flag_hit  = (kind == BK_FLAG);
    abort_hit = open_q && (kind == BK_ABORT);
    exit_vld  = data_push && (dly_cnt_q == DLY_C);
    asm_next  = {dly_q[0], asm_q[7:1]};
    byte_done = exit_vld && (phase_q == 3'd7);
    start_now = byte_done && !started_q && ((byte_cnt_q + 1'b1) >= min_n);
    frame_ok  = open_q && (byte_cnt_q >= min_n);
    pop       = (started_q || close_pend_q) && (level > HOLD_C) && !abort_hit;
    close_eof = close_pend_q && (level <= HOLD_C);
    abort_eof = abort_hit && started_q;
    eof_fire  = close_eof || abort_eof;
    flush     = close_eof || abort_hit || (flag_hit && open_q && !frame_ok);
    eof_stat  = abort_eof ? frm_stat_t'{crc_err: 1'b0, aborted: 1'b1, nonint: 1'b0} : stat_q;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      open_q       <= 1'b0;
      dly_q        <= '0;
      dly_cnt_q    <= '0;
      asm_q        <= '0;
      phase_q      <= '0;
      byte_cnt_q   <= '0;
      started_q    <= 1'b0;
      first_pend_q <= 1'b0;
      close_pend_q <= 1'b0;
      stat_q       <= '0;
      out_valid    <= 1'b0;
      out_first    <= 1'b0;
      eof_valid    <= 1'b0;
      eof_crc_err  <= 1'b0;
      eof_abort    <= 1'b0;
      eof_nonint   <= 1'b0;
    end else begin
      out_valid   <= pop;
      out_first   <= pop && first_pend_q;
      eof_valid   <= eof_fire;
      eof_crc_err <= eof_fire && eof_stat.crc_err;
      eof_abort   <= eof_fire && eof_stat.aborted;
      eof_nonint  <= eof_fire && eof_stat.nonint;

      if (pop)       first_pend_q <= 1'b0;
      if (close_eof) close_pend_q <= 1'b0;

      if (flag_hit) begin
        open_q     <= 1'b1;
        dly_cnt_q  <= '0;
        phase_q    <= '0;
        byte_cnt_q <= '0;
        started_q  <= 1'b0;
        if (frame_ok) begin
          close_pend_q <= 1'b1;
          stat_q <= frm_stat_t'{crc_err: !crc_good, aborted: 1'b0,
                                nonint: (phase_q != 3'd0)};
        end
      end else if (abort_hit) begin
        open_q     <= 1'b0;
        dly_cnt_q  <= '0;
        phase_q    <= '0;
        byte_cnt_q <= '0;
        started_q  <= 1'b0;
      end else if (data_push) begin
        dly_q <= {rx_bit, dly_q[DLY-1:1]};
        if (dly_cnt_q != DLY_C) dly_cnt_q <= dly_cnt_q + 1'b1;
        if (exit_vld) begin
          asm_q   <= asm_next;
          phase_q <= phase_q + 1'b1;
          if (byte_done && byte_cnt_q != CNT_MAX) byte_cnt_q <= byte_cnt_q + 1'b1;
        end
        if (start_now) begin
          started_q    <= 1'b1;
          first_pend_q <= 1'b1;
        end
      end
    end
  end

  assign out_data    = fifo_dout;
  assign line_active = open_q;
endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk (
  input logic clk,
  input logic rst,
  input logic rx_en,
  input logic bit_en,
  input logic rx_bit,
  input logic out_valid,
  input logic eof_valid,
  input logic line_active,
  input logic idle
);
  AST_LINE_RISE_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(line_active) |-> $past(bit_en && !rx_bit && rx_en)); // R8

  AST_IDLE_RISE_ON_ONE: assert property (@(posedge clk) disable iff (rst)
    $rose(idle) |-> $past(bit_en && rx_bit && rx_en)); // R5

  AST_SILENT_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (!out_valid && !eof_valid && !line_active)); // R7

  AST_EOF_NOT_WITH_BYTE: assert property (@(posedge clk) disable iff (rst)
    eof_valid |-> !out_valid); // R9

  AST_IDLE_NOT_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    idle |-> !line_active); // R4
endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk u_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .bit_en(bit_en), .rx_bit(rx_bit),
  .out_valid(out_valid), .eof_valid(eof_valid),
  .line_active(line_active), .idle(idle)
);

// File: tb/hdlc_rx_deframer_tb.sv
module hdlc_rx_deframer_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       is_eof;
    logic       first;
    logic [7:0] data;
    logic       crc;
    logic       abt;
    logic       nonint;
  } item_t;

  logic clk = 1'b0, rst = 1'b1, rx_en = 1'b0, bit_en = 1'b0, rx_bit = 1'b1;
  logic [1:0] min_len_sel = 2'b00;
  logic out_valid, out_first, eof_valid, eof_crc_err, eof_abort, eof_nonint;
  logic line_active, idle;
  logic [7:0] out_data;

  item_t exp_q[$];
  int n_checks = 0, n_errors = 0, stf = 0, nbits = 0;
  logic [7:0] pay [16];
  logic fbits [256];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_rx_deframer u_dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .min_len_sel(min_len_sel),
    .bit_en(bit_en), .rx_bit(rx_bit), .out_valid(out_valid), .out_first(out_first),
    .out_data(out_data), .eof_valid(eof_valid), .eof_crc_err(eof_crc_err),
    .eof_abort(eof_abort), .eof_nonint(eof_nonint), .line_active(line_active),
    .idle(idle)
  );

  function automatic logic [15:0] fcs_bit(input logic [15:0] c, input logic b);
    logic [15:0] r;
    r = c >> 1;
    if (c[0] ^ b) r = r ^ 16'h8408;
    return r;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && (out_valid || eof_valid)) begin
      item_t got, want;
      got = '{is_eof: eof_valid, first: out_valid ? out_first : 1'b0,
              data: out_valid ? out_data : 8'h00,
              crc: eof_valid ? eof_crc_err : 1'b0, abt: eof_valid ? eof_abort : 1'b0,
              nonint: eof_valid ? eof_nonint : 1'b0};
      n_checks++;
      if (out_valid && eof_valid) begin
        n_errors++;
        $display("FAIL R9: byte and end pulse together actual=%h expected=separate", got);
      end else if (exp_q.size() == 0) begin
        n_errors++;
        $display("FAIL R6/R9: unexpected output actual=%h expected=none", got);
      end else begin
        want = exp_q.pop_front();
        if (got !== want) begin
          n_errors++;
          $display("FAIL R1/R3/R4/R10: actual=%h expected=%h", got, want);
        end
      end
    end
  end

  task automatic send_raw(input logic b);
    @(negedge clk);
    rx_bit = b;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_flag();
    send_raw(1'b0);
    for (int i = 0; i < 6; i++) send_raw(1'b1);
    send_raw(1'b0);
    stf = 0;
  endtask

  // R2: zero insertion after five ones on the transmit side
  task automatic tx_bit(input logic b);
    send_raw(b);
    if (b) begin
      stf++;
      if (stf == 5) begin
        send_raw(1'b0);
        stf = 0;
      end
    end else stf = 0;
  endtask

  task automatic push_byte(input logic [7:0] d, input logic first);
    exp_q.push_back('{is_eof: 1'b0, first: first, data: d, crc: 1'b0, abt: 1'b0, nonint: 1'b0});
  endtask

  task automatic push_eof(input logic crc, input logic abt, input logic nonint);
    exp_q.push_back('{is_eof: 1'b1, first: 1'b0, data: 8'h00, crc: crc, abt: abt, nonint: nonint});
  endtask

  // Frame with check sequence, optional extra bits, then closing flag
  task automatic send_frame(input int len, input bit flip, input int extra, input bit live);
    logic [15:0] c, fcs;
    int minn;
    nbits = 0;
    c = 16'hFFFF;
    for (int i = 0; i < len; i++)
      for (int b = 0; b < 8; b++) begin
        fbits[nbits] = pay[i][b];
        c = fcs_bit(c, pay[i][b]);
        nbits++;
      end
    fcs = ~c;
    fcs[0] = fcs[0] ^ flip;
    for (int b = 0; b < 16; b++) begin
      fbits[nbits] = fcs[b];
      nbits++;
    end
    for (int b = 0; b < extra; b++) begin
      fbits[nbits] = (b % 2 == 0);
      nbits++;
    end
    c = 16'hFFFF;
    for (int k = 0; k < nbits; k++) c = fcs_bit(c, fbits[k]);
    minn = 3 + int'(min_len_sel);
    if (live && (len + 2) >= minn) begin
      for (int i = 0; i < len; i++) push_byte(pay[i], i == 0);
      push_eof(c != 16'hF0B8, 1'b0, extra != 0);
    end
    stf = 0;
    for (int k = 0; k < nbits; k++) tx_bit(fbits[k]);
    send_flag();
  endtask

  // Frame ended by a 0 and seven ones
  task automatic send_abort(input int len);
    int minn;
    minn = 3 + int'(min_len_sel);
    if (len >= minn) begin
      for (int i = 0; i < len - 2; i++) push_byte(pay[i], i == 0);
      push_eof(1'b0, 1'b1, 1'b0);
    end
    stf = 0;
    for (int i = 0; i < len; i++)
      for (int b = 0; b < 8; b++) tx_bit(pay[i][b]);
    send_raw(1'b0);
    for (int i = 0; i < 7; i++) send_raw(1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R11: reset state
    chk("R11 out_valid", out_valid, 1'b0);
    chk("R11 eof_valid", eof_valid, 1'b0);
    chk("R11 line_active", line_active, 1'b0);
    chk("R11 idle", idle, 1'b0);
    rst = 1'b0;
    rx_en = 1'b1;
    repeat (2) @(negedge clk);

    // R8: flag opens the line
    send_flag();
    chk("R8 line_active after flag", line_active, 1'b1);

    // R1 R2 R3: good frame with stuffing-heavy bytes
    pay[0] = 8'h7E; pay[1] = 8'hFF; pay[2] = 8'h3C; pay[3] = 8'hF8;
    send_frame(4, 1'b0, 0, 1'b1);
    // R3: corrupted check sequence
    pay[0] = 8'h01; pay[1] = 8'h80; pay[2] = 8'hAA;
    send_frame(3, 1'b1, 0, 1'b1);
    // R6: n=3, one data byte accepted, empty frame discarded
    pay[0] = 8'h55;
    send_frame(1, 1'b0, 0, 1'b1);
    send_frame(0, 1'b0, 0, 1'b1);
    // R6: n=6 (select 11): 5 bytes dropped, 6 bytes kept
    min_len_sel = 2'b11;
    pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'h33; pay[3] = 8'h44;
    send_frame(3, 1'b0, 0, 1'b1);
    send_frame(4, 1'b0, 0, 1'b1);
    min_len_sel = 2'b00;
    // R10: three extra bits before the closing flag
    pay[0] = 8'hC3; pay[1] = 8'h5A; pay[2] = 8'h0F;
    send_frame(3, 1'b0, 3, 1'b1);
    chk("R8 line_active across frames", line_active, 1'b1);

    // R4: abort after five bytes
    pay[0] = 8'hA1; pay[1] = 8'hB2; pay[2] = 8'hC3; pay[3] = 8'hD4; pay[4] = 8'hE5;
    send_abort(5);
    chk("R4 line_active after abort", line_active, 1'b0);
    // R4: abort of a short frame is silent
    send_flag();
    pay[0] = 8'h99;
    send_abort(1);
    // R5: 7 ones already sent; 7 more gives 14, then 15
    for (int i = 0; i < 7; i++) send_raw(1'b1);
    chk("R5 idle at 14 ones", idle, 1'b0);
    send_raw(1'b1);
    chk("R5 idle at 15 ones", idle, 1'b1);
    chk("R4 line_active while idle", line_active, 1'b0);
    send_raw(1'b0);
    chk("R5 idle cleared by zero", idle, 1'b0);

    // R7: receiver disabled
    send_flag();
    @(negedge clk);
    rx_en = 1'b0;
    pay[0] = 8'h12; pay[1] = 8'h34; pay[2] = 8'h56; pay[3] = 8'h78;
    send_flag();
    send_frame(4, 1'b0, 0, 1'b0);
    chk("R7 line_active while disabled", line_active, 1'b0);
    rx_en = 1'b1;
    @(negedge clk);
    chk("R7 line_active needs new flag", line_active, 1'b0);
    send_flag();
    pay[0] = 8'hDE; pay[1] = 8'hAD;
    send_frame(2, 1'b0, 0, 1'b1);

    repeat (40) @(negedge clk);
    // R9: nothing left over (check bytes never delivered)
    n_checks++;
    if (exp_q.size() != 0) begin
      n_errors++;
      $display("FAIL R9: pending expected items actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule